// File: doc/BRIEF.md
# Daisy-Chain Readout and Monitor Controller

This block is the back-end master for a set of serially chained front-end nodes. Each node holds a fixed-length frame. When the host asks for an event transfer, the controller raises the event/monitor mode line and pulses a trigger line once. It then presents module addresses from zero upward. For each module it generates a shift clock and samples the node's serial output once per bit. The transfer ends after the programmed number of modules has been read. The received bit stream is packed into 16-bit words and written into a small first-word-fall-through FIFO, which the host drains.

In monitor mode the mode line stays low and the controller drives the chain address, a monitor clock and a monitor reset. The host selects a module address. The first monitor clock pulse after that enables the selected node, and each later pulse steps it to its next channel. Frame length, module count and the shift-clock divider are set from host inputs. A diagnostic switch replaces the sampled serial data with a repeating 8-bit pattern.

Top module: `chain_readout_ctrl`

## Requirements
- R1: After reset the shift clock, mode line, trigger, monitor clock, monitor reset, busy, done and overflow outputs are low, and the FIFO reports empty.
- R2: An accepted event command holds the mode line high while busy. It presents addresses 0 to cfg_mod_cnt_i-1 in order and gives each address exactly cfg_frame_len_i shift-clock pulses. When the transfer ends, busy drops and done is high for exactly one cycle.
- R3: Every high phase and every low phase of the shift clock during a transfer lasts cfg_div_i+1 clock cycles. The shift clock is low whenever no transfer is running.
- R4: Serial data is sampled in the cycle in which the shift clock rises. Bits are packed most significant bit first into 16-bit words: the first bit of a transfer is bit 15 of the first word, and words enter the FIFO in arrival order.
- R5: If a transfer ends with fewer than 16 bits left over, those bits are written as one more word, left-justified, with zeros in the unused low bits.
- R6: rd_data_o shows the oldest word while fifo_empty_o is low, and rd_en_i removes it. A word that completes while the FIFO is full is dropped and sets fifo_ovf_o. fifo_ovf_o stays set until the next accepted event command clears it.
- R7: While tp_en_i is high, each sampled bit is replaced by tp_pattern_i bit 7-(n mod 8), where n counts the bits since the transfer started.
- R8: chain_trig_o is high for exactly one cycle per transfer, in the first busy cycle.
- R9: An accepted monitor-select command latches mon_addr_i. That address appears on chain_addr_o while no event transfer runs, with the mode line low.
- R10: A monitor-step command produces one monitor clock pulse: high for cfg_div_i+1 cycles, then low for cfg_div_i+1 cycles. A monitor-clear command drives the monitor reset high for cfg_div_i+1 cycles. The monitor clock and the monitor reset are never high together.
- R11: Any command that arrives while an event transfer or a monitor pulse is in progress is ignored. If an event command and a monitor command arrive in the same cycle, the event command wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | 8 | Shift-clock phase length minus one, in clock cycles |
| cfg_frame_len_i | input | 8 | Bits per module frame (1 or more) |
| cfg_mod_cnt_i | input | 5 | Modules per transfer (1 to 16) |
| tp_en_i | input | 1 | Replace serial data with the test pattern |
| tp_pattern_i | input | 8 | Diagnostic pattern, sent MSB first |
| evt_start_i | input | 1 | Event transfer command |
| mon_sel_i | input | 1 | Latch the monitor address |
| mon_addr_i | input | 4 | Monitor module address |
| mon_step_i | input | 1 | Issue one monitor clock pulse |
| mon_clr_i | input | 1 | Issue one monitor reset pulse |
| ser_data_i | input | 1 | Serial data returned by the chain |
| rd_en_i | input | 1 | Pop the FIFO head |
| chain_trig_o | output | 1 | Trigger line to the nodes |
| chain_mode_o | output | 1 | High for event mode, low for monitor mode |
| chain_addr_o | output | 4 | Module address on the chain |
| chain_clk_o | output | 1 | Event shift clock |
| mon_clk_o | output | 1 | Monitor channel-select clock |
| mon_rst_o | output | 1 | Monitor reset |
| evt_busy_o | output | 1 | Event transfer in progress |
| evt_done_o | output | 1 | One-cycle end-of-transfer flag |
| rd_data_o | output | 16 | FIFO head word |
| fifo_empty_o | output | 1 | FIFO holds no word |
| fifo_ovf_o | output | 1 | A word was dropped because the FIFO was full |

## Verification
The properties assume that the configuration inputs, and cfg_mod_cnt_i in particular, do not change while a transfer runs. The address-range check relies on this. The bench sets every configuration value at a falling edge before it issues a command and leaves it alone until done. The node model updates its output one cycle after it sees the shift clock fall, so the stimulus keeps cfg_div_i at one or more, which leaves the serial data settled before each rising-edge sample. Mid-transfer commands are injected on purpose, and the bench confirms at the ports that they change neither the word stream nor the monitor lines.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
  typedef enum logic [1:0] {EV_IDLE, EV_LOW, EV_HIGH, EV_FLUSH} ev_state_e;
  typedef enum logic [1:0] {MN_IDLE, MN_CLK_H, MN_CLK_L, MN_RST} mn_state_e;
endpackage

// File: rtl/chain_rd_tick.sv
module chain_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = active_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!active_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/chain_rd_evt_seq.sv
module chain_rd_evt_seq
  import chain_rd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W:0]   mods_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              sclk_o,
  output logic              smp_o,
  output logic              flush_o,
  output logic              trig_o,
  output logic              done_o
);
  ev_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  bit_q;
  logic              sclk_q, trig_q, done_q;
  logic              last_bit, last_mod;

  assign last_bit = (bit_q == len_i - 1'b1);
  assign last_mod = ({1'b0, addr_q} == mods_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EV_IDLE;
      addr_q  <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      done_q <= 1'b0;
      case (state_q)
        EV_IDLE: if (start_i) begin
          state_q <= EV_LOW;
          addr_q  <= '0;
          bit_q   <= '0;
          sclk_q  <= 1'b0;
          trig_q  <= 1'b1;
        end
        EV_LOW: if (tick_i) begin
          sclk_q  <= 1'b1;
          state_q <= EV_HIGH;
        end
        EV_HIGH: if (tick_i) begin
          sclk_q <= 1'b0;
          if (!last_bit) begin
            bit_q   <= bit_q + 1'b1;
            state_q <= EV_LOW;
          end else begin
            bit_q <= '0;
            if (last_mod) begin
              state_q <= EV_FLUSH;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= EV_LOW;
            end
          end
        end
        EV_FLUSH: begin
          state_q <= EV_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= EV_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != EV_IDLE);
  assign addr_o  = addr_q;
  assign sclk_o  = sclk_q;
  assign smp_o   = (state_q == EV_LOW) && tick_i;
  assign flush_o = (state_q == EV_FLUSH);
  assign trig_o  = trig_q;
  assign done_o  = done_q;
endmodule

// File: rtl/chain_rd_packer.sv
module chain_rd_packer #(
  parameter int WORD_W = 16,
  parameter int TP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              smp_i,
  input  logic              bit_i,
  input  logic              flush_i,
  input  logic              tp_en_i,
  input  logic [TP_W-1:0]   tp_pat_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int TPI_W = $clog2(TP_W);

  logic [WORD_W-2:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TPI_W-1:0]  tp_idx_q;
  logic              d_bit, word_full;

  assign d_bit     = tp_en_i ? tp_pat_i[TPI_W'(TP_W-1) - tp_idx_q] : bit_i;
  assign word_full = (cnt_q == CNT_W'(WORD_W-1));
  assign push_o    = (smp_i && word_full) || (flush_i && (cnt_q != '0));
  // flush: left-justify the residual bits, zero fill below
  assign word_o    = smp_i ? {sr_q, d_bit}
                           : ({sr_q, 1'b0} << (CNT_W'(WORD_W-1) - cnt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      tp_idx_q <= '0;
    end else if (clear_i) begin
      cnt_q    <= '0;
      tp_idx_q <= '0;
    end else if (smp_i) begin
      tp_idx_q <= tp_idx_q + 1'b1;
      sr_q     <= {sr_q[WORD_W-3:0], d_bit};
      cnt_q    <= word_full ? '0 : cnt_q + 1'b1;
    end else if (flush_i) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/chain_rd_fifo.sv
module chain_rd_fifo #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_ovf_i,
  input  logic              push_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] data_o,
  output logic              empty_o,
  output logic              ovf_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PTR_W:0]    wp_q, rp_q;
  logic              full, do_pop, ovf_q;

  assign full    = (wp_q[PTR_W] != rp_q[PTR_W]) && (wp_q[PTR_W-1:0] == rp_q[PTR_W-1:0]);
  assign empty_o = (wp_q == rp_q);
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q[PTR_W-1:0]];
  assign ovf_o   = ovf_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[wp_q[PTR_W-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_i && !full) wp_q <= wp_q + 1'b1;
      if (do_pop)          rp_q <= rp_q + 1'b1;
      if (clear_ovf_i)          ovf_q <= 1'b0;
      else if (push_i && full)  ovf_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chain_rd_mon_seq.sv
module chain_rd_mon_seq
  import chain_rd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              step_i,
  input  logic              clr_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mclk_o,
  output logic              mrst_o
);
  mn_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MN_IDLE;
      addr_q  <= '0;
    end else begin
      if (sel_i) addr_q <= addr_i;
      case (state_q)
        MN_IDLE: begin
          if (clr_i)       state_q <= MN_RST;
          else if (step_i) state_q <= MN_CLK_H;
        end
        MN_CLK_H: if (tick_i) state_q <= MN_CLK_L;
        MN_CLK_L: if (tick_i) state_q <= MN_IDLE;
        MN_RST:   if (tick_i) state_q <= MN_IDLE;
        default:  state_q <= MN_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != MN_IDLE);
  assign addr_o = addr_q;
  assign mclk_o = (state_q == MN_CLK_H);
  assign mrst_o = (state_q == MN_RST);
endmodule

// File: rtl/chain_readout_ctrl.sv
module chain_readout_ctrl #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  parameter int LEN_W  = 8,
  parameter int TP_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [LEN_W-1:0]  cfg_frame_len_i,
  input  logic [ADDR_W:0]   cfg_mod_cnt_i,
  input  logic              tp_en_i,
  input  logic [TP_W-1:0]   tp_pattern_i,
  input  logic              evt_start_i,
  input  logic              mon_sel_i,
  input  logic [ADDR_W-1:0] mon_addr_i,
  input  logic              mon_step_i,
  input  logic              mon_clr_i,
  input  logic              ser_data_i,
  input  logic              rd_en_i,
  output logic              chain_trig_o,
  output logic              chain_mode_o,
  output logic [ADDR_W-1:0] chain_addr_o,
  output logic              chain_clk_o,
  output logic              mon_clk_o,
  output logic              mon_rst_o,
  output logic              evt_busy_o,
  output logic              evt_done_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              fifo_empty_o,
  output logic              fifo_ovf_o
);
  logic              tick, any_busy, evt_busy, mon_busy;
  logic              evt_go, mon_ok;
  logic              smp, flush, push;
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] evt_addr, mon_addr;

  assign any_busy = evt_busy || mon_busy;
  assign evt_go   = evt_start_i && !any_busy;
  assign mon_ok   = !any_busy && !evt_start_i;  // event command wins a tie

  chain_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .active_i(any_busy), .div_i(cfg_div_i), .tick_o(tick)
  );

  chain_rd_evt_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_evt (
    .clk_i, .rst_ni,
    .start_i (evt_go),
    .tick_i  (tick),
    .len_i   (cfg_frame_len_i),
    .mods_i  (cfg_mod_cnt_i),
    .busy_o  (evt_busy),
    .addr_o  (evt_addr),
    .sclk_o  (chain_clk_o),
    .smp_o   (smp),
    .flush_o (flush),
    .trig_o  (chain_trig_o),
    .done_o  (evt_done_o)
  );

  chain_rd_packer #(.WORD_W(WORD_W), .TP_W(TP_W)) u_pack (
    .clk_i, .rst_ni,
    .clear_i  (evt_go),
    .smp_i    (smp),
    .bit_i    (ser_data_i),
    .flush_i  (flush),
    .tp_en_i  (tp_en_i),
    .tp_pat_i (tp_pattern_i),
    .push_o   (push),
    .word_o   (word)
  );

  chain_rd_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .clear_ovf_i (evt_go),
    .push_i      (push),
    .data_i      (word),
    .pop_i       (rd_en_i),
    .data_o      (rd_data_o),
    .empty_o     (fifo_empty_o),
    .ovf_o       (fifo_ovf_o)
  );

  chain_rd_mon_seq #(.ADDR_W(ADDR_W)) u_mon (
    .clk_i, .rst_ni,
    .sel_i  (mon_sel_i && mon_ok),
    .addr_i (mon_addr_i),
    .step_i (mon_step_i && mon_ok),
    .clr_i  (mon_clr_i && mon_ok),
    .tick_i (tick),
    .busy_o (mon_busy),
    .addr_o (mon_addr),
    .mclk_o (mon_clk_o),
    .mrst_o (mon_rst_o)
  );

  assign evt_busy_o   = evt_busy;
  assign chain_mode_o = evt_busy;
  assign chain_addr_o = evt_busy ? evt_addr : mon_addr;
endmodule

// File: rtl/chain_readout_ctrl_chk.sv
module chain_readout_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W:0]   cfg_mod_cnt_i,
  input logic              evt_start_i,
  input logic              chain_trig_o,
  input logic              chain_mode_o,
  input logic [ADDR_W-1:0] chain_addr_o,
  input logic              chain_clk_o,
  input logic              evt_busy_o,
  input logic              evt_done_o,
  input logic              mon_clk_o,
  input logic              mon_rst_o,
  input logic              fifo_ovf_o
);
  // R2
  busy_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_busy_o |-> chain_mode_o);
  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_busy_o |-> ({1'b0, chain_addr_o} < cfg_mod_cnt_i));
  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |-> !evt_busy_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |=> !evt_done_o);
  // R8
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_trig_o |=> !chain_trig_o);
  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_busy_o |-> !chain_clk_o);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_ovf_o && !evt_start_i) |=> fifo_ovf_o);
  // R10
  mon_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mon_clk_o && mon_rst_o));
  // R11
  mon_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_busy_o |-> (!mon_clk_o && !mon_rst_o));
endmodule

bind chain_readout_ctrl chain_readout_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_mod_cnt_i (cfg_mod_cnt_i),
  .evt_start_i   (evt_start_i),
  .chain_trig_o  (chain_trig_o),
  .chain_mode_o  (chain_mode_o),
  .chain_addr_o  (chain_addr_o),
  .chain_clk_o   (chain_clk_o),
  .evt_busy_o    (evt_busy_o),
  .evt_done_o    (evt_done_o),
  .mon_clk_o     (mon_clk_o),
  .mon_rst_o     (mon_rst_o),
  .fifo_ovf_o    (fifo_ovf_o)
);

// File: tb/chain_readout_ctrl_tb_top.sv
module chain_readout_ctrl_tb_top;
  localparam int ADDR_W = 4, WORD_W = 16, DEPTH = 8, DIV_W = 8, LEN_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [DIV_W-1:0]  cfg_div_i = 8'd1;
  logic [LEN_W-1:0]  cfg_frame_len_i = 8'd48;
  logic [ADDR_W:0]   cfg_mod_cnt_i = 5'd1;
  logic              tp_en_i = 1'b0;
  logic [7:0]        tp_pattern_i = 8'h00;
  logic              evt_start_i = 1'b0, mon_sel_i = 1'b0, mon_step_i = 1'b0, mon_clr_i = 1'b0;
  logic [ADDR_W-1:0] mon_addr_i = '0;
  logic              ser_data_i, rd_en_i = 1'b0;
  logic              chain_trig_o, chain_mode_o, chain_clk_o, mon_clk_o, mon_rst_o;
  logic [ADDR_W-1:0] chain_addr_o;
  logic              evt_busy_o, evt_done_o, fifo_empty_o, fifo_ovf_o;
  logic [WORD_W-1:0] rd_data_o;

  always #5 clk_i = ~clk_i;

  chain_readout_ctrl dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  logic [WORD_W-1:0] exp_q[$];

  function automatic bit node_bit(int m, int i);
    return ((m * 5 + i * 3 + (i >> 3)) % 7) < 3;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // node model: advances one bit after each falling shift-clock edge
  int   node_idx = 0;
  logic prev_sclk = 1'b0;
  always @(posedge clk_i) begin
    if (chain_trig_o) node_idx <= 0;
    else if (prev_sclk && !chain_clk_o)
      node_idx <= (node_idx == int'(cfg_frame_len_i) - 1) ? 0 : node_idx + 1;
    prev_sclk <= chain_clk_o;
  end
  assign ser_data_i = node_bit(int'(chain_addr_o), node_idx);

  // observer
  int   rise_cnt, max_addr, run_len, run_min, run_max, trig_cnt, mode_bad, mon_hits;
  logic obs_prev = 1'b0;
  always @(negedge clk_i) begin
    if (evt_busy_o) begin
      if (!chain_mode_o) mode_bad++;
      if (mon_clk_o || mon_rst_o) mon_hits++;
      if (chain_trig_o) trig_cnt++;
      if (int'(chain_addr_o) > max_addr) max_addr = int'(chain_addr_o);
      if (chain_clk_o && !obs_prev) rise_cnt++;
      if (run_len == 0) run_len = 1;
      else if (chain_clk_o == obs_prev) run_len++;
      else begin
        if (run_len < run_min) run_min = run_len;
        if (run_len > run_max) run_max = run_len;
        run_len = 1;
      end
    end else run_len = 0;
    obs_prev = chain_clk_o;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drain(string req);
    while (!fifo_empty_o) begin
      if (exp_q.size() == 0) chk(1'b0, req, rd_data_o, 0);
      else begin
        logic [WORD_W-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data_o == e, req, rd_data_o, e);
      end
      rd_en_i = 1'b1;
      @(negedge clk_i);
      rd_en_i = 1'b0;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic run_event(int div, int len, int nmod, bit tp, logic [7:0] pat,
                           bit poke, string req);
    logic [WORD_W-1:0] acc = '0;
    int nb = 0, pushed = 0;
    bit exp_ovf = 0;
    @(negedge clk_i);
    cfg_div_i = DIV_W'(div); cfg_frame_len_i = LEN_W'(len);
    cfg_mod_cnt_i = 5'(nmod); tp_en_i = tp; tp_pattern_i = pat;
    rise_cnt = 0; max_addr = 0; run_len = 0; run_min = 1 << 20; run_max = 0;
    trig_cnt = 0; mode_bad = 0; mon_hits = 0;
    for (int k = 0; k < len * nmod; k++) begin
      bit b;
      b = tp ? pat[7 - (k % 8)] : node_bit(k / len, k % len);
      acc = {acc[WORD_W-2:0], b};
      nb++;
      if (nb == WORD_W) begin
        if (pushed < DEPTH) exp_q.push_back(acc); else exp_ovf = 1;
        pushed++; nb = 0;
      end
    end
    if (nb != 0) begin
      if (pushed < DEPTH) exp_q.push_back(acc << (WORD_W - nb)); else exp_ovf = 1;
    end
    evt_start_i = 1'b1;
    @(negedge clk_i);
    evt_start_i = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk_i);
      evt_start_i = 1'b1; mon_step_i = 1'b1; mon_clr_i = 1'b1;
      @(negedge clk_i);
      evt_start_i = 1'b0; mon_step_i = 1'b0; mon_clr_i = 1'b0;
    end
    while (!evt_done_o) @(negedge clk_i);
    chk(!evt_busy_o, "R2 busy low at done", evt_busy_o, 0);
    chk(rise_cnt == len * nmod, "R2 shift pulses", rise_cnt, len * nmod);
    chk(max_addr == nmod - 1, "R2 last address", max_addr, nmod - 1);
    chk(mode_bad == 0, "R2 mode high while busy", mode_bad, 0);
    chk(trig_cnt == 1, "R8 trigger pulses", trig_cnt, 1);
    chk(run_min == div + 1 && run_max == div + 1, "R3 phase length", run_max, div + 1);
    chk(fifo_ovf_o == exp_ovf, "R6 overflow flag", fifo_ovf_o, exp_ovf);
    @(negedge clk_i);
    chk(!evt_done_o, "R2 done single cycle", evt_done_o, 0);
    if (poke) begin
      chk(mon_hits == 0, "R11 monitor quiet during event", mon_hits, 0);
      repeat (12) begin
        chk(!mon_clk_o && !mon_rst_o && !evt_busy_o, "R11 command ignored", mon_clk_o, 0);
        @(negedge clk_i);
      end
    end
    drain(req);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R1
    chk(!chain_clk_o && !chain_mode_o && !chain_trig_o, "R1 chain lines", chain_clk_o, 0);
    chk(!mon_clk_o && !mon_rst_o, "R1 monitor lines", mon_clk_o, 0);
    chk(!evt_busy_o && !evt_done_o && !fifo_ovf_o, "R1 status", evt_busy_o, 0);
    chk(fifo_empty_o, "R1 fifo empty", fifo_empty_o, 1);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_event(1, 48, 2, 0, 8'h00, 0, "R4 two modules");
    run_event(2, 32, 2, 0, 8'h00, 1, "R11 mid-transfer commands");
    run_event(1, 20, 1, 0, 8'h00, 0, "R5 partial word");
    run_event(1, 48, 1, 1, 8'hA5, 0, "R7 test pattern");
    run_event(1, 8, 16, 0, 8'h00, 0, "R2 sixteen modules");
    run_event(1, 48, 3, 0, 8'h00, 0, "R6 overflow drop");
    run_event(1, 16, 1, 0, 8'h00, 0, "R6 overflow cleared");

    // R9 monitor select
    mon_addr_i = 4'd9; mon_sel_i = 1'b1;
    @(negedge clk_i);
    mon_sel_i = 1'b0;
    chk(chain_addr_o == 4'd9, "R9 monitor address", chain_addr_o, 9);
    chk(!chain_mode_o, "R9 mode low", chain_mode_o, 0);

    // R10 monitor step
    cfg_div_i = 8'd3; mon_step_i = 1'b1;
    @(negedge clk_i);
    mon_step_i = 1'b0;
    n = 0;
    while (mon_clk_o && n < 100) begin n++; @(negedge clk_i); end
    chk(n == 4, "R10 monitor clock high", n, 4);
    mon_step_i = 1'b1;
    @(negedge clk_i);
    mon_step_i = 1'b0;
    n = 0;
    repeat (10) begin if (mon_clk_o) n++; @(negedge clk_i); end
    chk(n == 0, "R11 step during low phase ignored", n, 0);
    mon_clr_i = 1'b1;
    @(negedge clk_i);
    mon_clr_i = 1'b0;
    n = 0;
    while (mon_rst_o && n < 100) begin
      if (mon_clk_o) chk(1'b0, "R10 clock during reset", 1, 0);
      n++; @(negedge clk_i);
    end
    chk(n == 4, "R10 monitor reset high", n, 4);
    chk(chain_addr_o == 4'd9, "R9 address held", chain_addr_o, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule